// File: doc/BRIEF.md
# Line-Tagged Receive Queue

This block is the shared receive queue of a four-line serial multiplexer. Every received byte enters together with the two-bit number of the line it arrived on, and both are kept side by side in one circular buffer. Software empties the queue through one read strobe: each strobe removes the oldest entry and presents it as a packed 16-bit word carrying a valid flag, the line number and the byte. An empty queue answers a strobe with an all-zero word and is left untouched.

One line, chosen by a parameter, carries traffic from a pointing device, which can flood the queue. Once more than half of the queue is occupied, bytes from that line are thrown away while the other three lines keep being accepted. A push that brings the write pointer onto the read pointer sets a sticky overrun flag; a non-empty flag drives the interrupt logic of the multiplexer.

Top module: `line_tag_rx_queue`

## Requirements
- R1: After reset, `nonempty_o` is 0, `overrun_o` is 0 and `rd_word_o` is 0.
- R2: A push is stored when accepted; `nonempty_o` reads 1 in the cycle after the clock edge that takes the first entry.
- R3: Entries come out in the order they were accepted, whatever line they came from.
- R4: In the cycle after a strobe on `pop_i` with the queue non-empty, `rd_word_o` holds bit 15 = 1, bits 9:8 = line number, bits 7:0 = byte and all other bits 0; the word holds until the next strobe.
- R5: A strobe on an empty queue gives `rd_word_o` = 0 in the next cycle and moves no pointer, so the next byte pushed is the next byte read.
- R6: With the occupancy before the push greater than DEPTH/2, a push whose line equals MOUSE_LINE (default 1) is discarded; pushes from the other lines are accepted; at an occupancy of exactly DEPTH/2 a push from MOUSE_LINE is still accepted.
- R7: `nonempty_o` is 1 exactly while the read and write pointers differ; it returns to 0 in the cycle after the last entry is removed.
- R8: A push made with DEPTH-1 entries held makes the write pointer equal to the read pointer: `overrun_o` goes to 1 and stays 1 until reset, and the queue then reads as empty.
- R9: A push and a strobe in the same cycle both take effect: the oldest entry is returned and the new byte joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push strobe for one received byte |
| push_char_i | input | 8 | Received byte |
| push_line_i | input | 2 | Line the byte arrived on |
| pop_i | input | 1 | Read strobe, removes the oldest entry |
| rd_word_o | output | 16 | Packed word from the last strobe |
| nonempty_o | output | 1 | Queue holds at least one entry |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench runs with a 32-entry queue and goes after the drop threshold on both sides: at exactly half full a pointing-device byte must enter, one entry later it must vanish while a byte from another line still enters; an off-by-one comparison would show up as a missing or an extra byte in the drained sequence. A strobe on an empty queue is followed by a push to prove that no pointer moved, since a design that advanced anyway would return a stale entry or lose the new one. Simultaneous push and strobe, and the overrun push that wraps the write pointer onto the read pointer, are checked through the returned words, the non-empty flag and the sticky overrun flag, which must survive further traffic and clear only on reset.

// File: rtl/lrq_pkg.sv
package lrq_pkg;
  localparam int CHAR_W   = 8;
  localparam int LINE_W   = 2;
  localparam int ENTRY_W  = CHAR_W + LINE_W;
  localparam int WORD_W   = 16;
  localparam int FLAG_BIT = 15;
  localparam int LINE_LSB = 8;

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } lrq_entry_t;

  function automatic logic [WORD_W-1:0] pack_word(input lrq_entry_t e);
    logic [WORD_W-1:0] w;
    w = '0;
    w[FLAG_BIT] = 1'b1;
    w[LINE_LSB +: LINE_W] = e.line;
    w[CHAR_W-1:0] = e.ch;
    return w;
  endfunction
endpackage

// File: rtl/lrq_ram.sv
module lrq_ram #(
  parameter int DEPTH = 4096,
  parameter int DW    = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // one write port, one registered read port: maps onto a simple dual-port block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lrq_ctrl.sv
module lrq_ctrl #(
  parameter int DEPTH      = 4096,
  parameter int MOUSE_LINE = 1,
  localparam int AW        = $clog2(DEPTH),
  localparam int HALF      = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [1:0]    line_i,
  input  logic          pop_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          nonempty_o,
  output logic          overrun_o,
  output logic          hit_o
);
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt, occ;
  logic          mouse_drop, accept, take;

  assign occ        = wr_ptr - rd_ptr;
  assign nonempty_o = (wr_ptr != rd_ptr);
  assign mouse_drop = (line_i == 2'(MOUSE_LINE)) && (occ > AW'(HALF));
  assign accept     = push_i && !mouse_drop;
  assign take       = pop_i && nonempty_o;
  assign wr_nxt     = accept ? wr_ptr + 1'b1 : wr_ptr;
  assign rd_nxt     = take ? rd_ptr + 1'b1 : rd_ptr;

  assign wr_en_o   = accept;
  assign wr_addr_o = wr_ptr;
  assign rd_en_o   = take;
  assign rd_addr_o = rd_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      overrun_o <= 1'b0;
      hit_o     <= 1'b0;
    end else begin
      wr_ptr <= wr_nxt;
      rd_ptr <= rd_nxt;
      if (accept && (wr_nxt == rd_nxt)) overrun_o <= 1'b1;
      if (pop_i) hit_o <= take;
    end
  end

  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !nonempty_o && !push_i) |=> ($stable(rd_ptr) && $stable(wr_ptr))); // R5

  AST_MOUSE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (push_i && line_i == 2'(MOUSE_LINE) && occ > AW'(HALF) && !pop_i) |=> $stable(wr_ptr)); // R6

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o); // R8

  AST_OCC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!overrun_o && !(push_i && occ == AW'(DEPTH-1))) |=>
      (occ == $past(occ) || occ == $past(occ) + 1'b1 || occ == $past(occ) - 1'b1)); // R9
endmodule

// File: rtl/line_tag_rx_queue.sv
module line_tag_rx_queue
  import lrq_pkg::*;
#(
  parameter int DEPTH      = 4096,
  parameter int MOUSE_LINE = 1,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [CHAR_W-1:0] push_char_i,
  input  logic [LINE_W-1:0] push_line_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              nonempty_o,
  output logic              overrun_o
);
  logic          wr_en, rd_en, hit;
  logic [AW-1:0] wr_addr, rd_addr;
  lrq_entry_t    wr_entry, rd_entry;

  assign wr_entry.line = push_line_i;
  assign wr_entry.ch   = push_char_i;

  lrq_ctrl #(.DEPTH(DEPTH), .MOUSE_LINE(MOUSE_LINE)) ctrl_i (
    .clk(clk), .rst(rst), .push_i(push_i), .line_i(push_line_i), .pop_i(pop_i),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .nonempty_o(nonempty_o), .overrun_o(overrun_o), .hit_o(hit)
  );

  lrq_ram #(.DEPTH(DEPTH), .DW(ENTRY_W)) ram_i (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_entry),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_entry)
  );

  assign rd_word_o = hit ? pack_word(rd_entry) : '0;

  always_comb begin
    AST_WORD_SPARE_ZERO: assert (rst || rd_word_o[14:10] == '0); // R4
  end

  AST_EMPTY_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !nonempty_o) |=> (rd_word_o == '0)); // R5

  AST_FULL_WORD_FLAG: assert property (@(posedge clk) disable iff (rst)
    (pop_i && nonempty_o) |=> rd_word_o[FLAG_BIT]); // R4
endmodule

// File: tb/line_tag_rx_queue_tb_top.sv
module line_tag_rx_queue_tb_top;
  localparam int DEPTH = 32;
  localparam int MOUSE = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_i = 1'b0;
  logic [7:0]  push_char_i = '0;
  logic [1:0]  push_line_i = '0;
  logic        pop_i = 1'b0;
  logic [15:0] rd_word_o;
  logic        nonempty_o, overrun_o;

  int n_checks = 0;
  int n_fail   = 0;

  // scoreboard model
  logic [9:0] exp_q[$];
  bit         m_over = 1'b0;

  always #10 clk = ~clk;

  line_tag_rx_queue #(.DEPTH(DEPTH), .MOUSE_LINE(MOUSE)) dut_i (
    .clk(clk), .rst(rst), .push_i(push_i), .push_char_i(push_char_i),
    .push_line_i(push_line_i), .pop_i(pop_i), .rd_word_o(rd_word_o),
    .nonempty_o(nonempty_o), .overrun_o(overrun_o)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input logic [9:0] e);
    return {1'b1, 5'b0, e[9:8], e[7:0]};
  endfunction

  // model a push against the pre-edge state; pop_taken says a pop removed one entry
  function automatic void model_push(input logic [1:0] ln, input logic [7:0] ch, input int pre_cnt, input bit pop_taken);
    if (ln == 2'(MOUSE) && pre_cnt > DEPTH / 2) return;
    if (!pop_taken && pre_cnt == DEPTH - 1) begin
      exp_q.delete();
      m_over = 1'b1;
    end else begin
      exp_q.push_back({ln, ch});
    end
  endfunction

  // driver: called at a negedge, returns at the next negedge
  task automatic push(input logic [1:0] ln, input logic [7:0] ch, input string req);
    int pre = exp_q.size();
    push_i = 1'b1; push_line_i = ln; push_char_i = ch;
    model_push(ln, ch, pre, 1'b0);
    @(negedge clk);
    push_i = 1'b0;
    check({req, " R7 nonempty"}, 16'(nonempty_o), 16'(exp_q.size() != 0));
  endtask

  // monitor: pops and compares against the scoreboard front
  task automatic pop(input string req);
    logic [15:0] exp;
    exp = (exp_q.size() != 0) ? word_of(exp_q.pop_front()) : 16'h0000;
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0;
    check({req, " word"}, rd_word_o, exp);
    check({req, " R7 nonempty"}, 16'(nonempty_o), 16'(exp_q.size() != 0));
  endtask

  task automatic push_pop(input logic [1:0] ln, input logic [7:0] ch);
    logic [15:0] exp;
    int pre = exp_q.size();
    exp = (pre != 0) ? word_of(exp_q.pop_front()) : 16'h0000;
    model_push(ln, ch, pre, pre != 0);
    push_i = 1'b1; push_line_i = ln; push_char_i = ch; pop_i = 1'b1;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
    check("R9 simultaneous word", rd_word_o, exp);
  endtask

  task automatic drain(input string req);
    while (exp_q.size() != 0) pop(req);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 nonempty", 16'(nonempty_o), 16'h0);
    check("R1 overrun", 16'(overrun_o), 16'h0);
    check("R1 word", rd_word_o, 16'h0);

    // R2 R3 R4: mixed lines, FIFO order and packing
    push(2'd0, 8'h41, "R2");
    push(2'd2, 8'hC3, "R2");
    push(2'd3, 8'h7E, "R2");
    push(2'd1, 8'h00, "R2");
    pop("R3 R4");
    check("R4 word held", rd_word_o, 16'h8041);
    @(negedge clk);
    check("R4 word held next cycle", rd_word_o, 16'h8041);
    drain("R3 R4");
    // R5: empty strobe then push
    pop("R5 empty");
    push(2'd3, 8'h5A, "R5");
    pop("R5 after empty");
    pop("R5 empty again");

    // R6: threshold on both sides
    for (int i = 0; i < DEPTH / 2; i++) push(2'(i % 4 == 1 ? 0 : i % 4), 8'(i + 8'h10), "R6 fill");
    push(2'd1, 8'hA1, "R6 at half accepted");
    push(2'd1, 8'hA2, "R6 above half dropped");
    push(2'd2, 8'hA3, "R6 other line accepted");
    check("R6 depth model", 16'(exp_q.size()), 16'(DEPTH / 2 + 2));
    drain("R6 R3");

    // R9: push and pop together
    push(2'd0, 8'h11, "R9");
    push(2'd1, 8'h22, "R9");
    push_pop(2'd2, 8'h33);
    push_pop(2'd3, 8'h44);
    drain("R9");

    // R8: overrun via non-mouse lines
    for (int i = 0; i < DEPTH - 1; i++) push(2'd2, 8'(i), "R8 fill");
    check("R8 no overrun yet", 16'(overrun_o), 16'h0);
    push(2'd3, 8'hEE, "R8 wrap");
    check("R8 overrun set", 16'(overrun_o), 16'(m_over));
    check("R8 reads empty", 16'(nonempty_o), 16'h0);
    pop("R8 empty after wrap");
    push(2'd0, 8'h99, "R8");
    pop("R8 after wrap");
    check("R8 overrun sticky", 16'(overrun_o), 16'h1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    check("R1 R8 overrun cleared by reset", 16'(overrun_o), 16'h0);
    check("R1 word after reset", rd_word_o, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule